// File: doc/BRIEF.md
# Rank-Selected Issue Queue

This block holds a small, fixed number of dispatched instructions and decides which one goes to execution each cycle. Every occupied slot is in one of three phases: waiting for its inputs, ready to go, or executing. A newly dispatched instruction lands in the lowest free slot. It enters the ready phase at once if both its register operands and its memory ordering are already satisfied. Otherwise it waits for wakeup pulses that name its slot index.

Each cycle one ready slot is picked. The pick favours the lowest value of "age index minus number of dependent consumers", and the older instruction wins a tie. The pick is issued only while the execution-resource input is high. Issued slots count their latency down and leave the queue with a completion pulse. The dispatch side reports an encoded stall reason, and it lets zero-latency or urgent instructions skip the ready pool.

The load/store queues, renaming and the resource model sit outside the block. Only their full and available signals enter it.

Top module: `rank_issue_queue`

## Requirements
- R1: `disp_status` reports 0 when dispatch is possible, 1 for a load while `ldq_full` is high, 2 for a store while `stq_full` is high, 3 when no slot is free, and 4 when `group_stall` is high. The checks are made in that priority order (1 first, 4 last).
- R2: A dispatch is accepted (`disp_accept`) only when `disp_valid` is high and the status is 0. A rejected dispatch leaves the queue unchanged.
- R3: An accepted instruction with `disp_opnd_rdy` and `disp_mem_clr` both high becomes ready after the accepting edge. Otherwise it waits.
- R4: A waiting slot records `wake_valid`/`wake_idx` and `mclr_valid`/`mclr_idx` pulses that name it. It becomes ready at the edge where both conditions have been met, and it never becomes ready on one of them alone.
- R5: Among ready slots, the one with the lowest signed rank (age minus consumers, 9-bit) is issued.
- R6: When ranks are equal, the slot with the smaller signed age is issued.
- R7: `issue_valid` is low when no slot is ready or when `res_avail` is low.
- R8: A slot issued with latency L is flagged in `done_mask` during the cycle after the L-th clock edge that follows its issue edge. The slot becomes free at the next edge.
- R9: An accepted instruction that is ready at dispatch, has latency 0 or `disp_urgent` set, and sees `res_avail` high issues in its dispatch cycle on `disp_slot`. Urgent slots in the ready pool win over any rank.
- R10: A dispatch takes the lowest-numbered free slot, and that slot is reported on `disp_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_age | input | 8 | Signed age index of the instruction |
| disp_users | input | 4 | Number of dependent consumers |
| disp_lat | input | 4 | Execution latency in cycles |
| disp_opnd_rdy | input | 1 | Register operands already available |
| disp_mem_clr | input | 1 | Memory dependencies already satisfied |
| disp_is_load | input | 1 | Instruction is a load |
| disp_is_store | input | 1 | Instruction is a store |
| disp_urgent | input | 1 | Instruction must issue without waiting |
| ldq_full | input | 1 | Load queue has no room |
| stq_full | input | 1 | Store queue has no room |
| group_stall | input | 1 | Dispatch group must stall |
| disp_status | output | 3 | Encoded stall reason (R1) |
| disp_accept | output | 1 | Dispatch taken this cycle |
| disp_slot | output | 3 | Slot given to the dispatch |
| wake_valid | input | 1 | Operand wakeup pulse |
| wake_idx | input | 3 | Slot woken |
| mclr_valid | input | 1 | Memory-clear pulse |
| mclr_idx | input | 3 | Slot cleared |
| res_avail | input | 1 | Execution resource free this cycle |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_idx | output | 3 | Slot issued |
| issue_age | output | 8 | Age index of the issued instruction |
| done_mask | output | 8 | Slots retiring at the next edge |

## Verification
The assertions assume that the wakeup and memory-clear pulses name occupied slots. They also assume that ages held at the same time are distinct and do not wrap. Outside those conditions, the rank and tie order would not mean age order. The stimulus gives every instruction in one scenario a distinct age. It resets the queue between scenarios, and it sends pulses only to slot numbers it read back from `disp_slot`.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int AGE_W = 8;
    localparam int USR_W = 4;
    localparam int LAT_W = 4;
    localparam int RNK_W = AGE_W + 1;

    typedef enum logic [1:0] {PH_FREE, PH_WAIT, PH_READY, PH_EXEC} phase_e;
    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_LDQ   = 3'd1,
        ST_STQ   = 3'd2,
        ST_FULL  = 3'd3,
        ST_GROUP = 3'd4
    } disp_st_e;

    typedef logic signed [AGE_W-1:0] age_t;
    typedef logic [USR_W-1:0]        usr_t;
    typedef logic [LAT_W-1:0]        lat_t;
    typedef logic signed [RNK_W-1:0] rank_t;

    typedef struct packed {
        age_t age;
        usr_t users;
        lat_t lat;
        logic urgent;
        logic op_rdy;
        logic mem_clr;
    } disp_t;

    function automatic rank_t rank_of(age_t a, usr_t u);
        rank_t ea, eu;
        ea = {a[AGE_W-1], a};
        eu = {{(RNK_W-USR_W){1'b0}}, u};
        return ea - eu;
    endfunction

    // true when candidate a should be picked over incumbent b
    function automatic logic beats(logic ua, rank_t ra, age_t aa,
                                   logic ub, rank_t rb, age_t ab);
        if (ua != ub) return ua;
        if (ra != rb) return ra < rb;
        return aa < ab;
    endfunction
endpackage

// File: rtl/iq_admit.sv
module iq_admit
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] free_vec,
    input  logic             is_load,
    input  logic             is_store,
    input  logic             ldq_full,
    input  logic             stq_full,
    input  logic             group_stall,
    output disp_st_e         status,
    output logic [IDX_W-1:0] slot
);
    logic any_free;

    always_comb begin
        any_free = |free_vec;
        slot     = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) slot = IDX_W'(i);
        end
        if (is_load && ldq_full)       status = ST_LDQ;
        else if (is_store && stq_full) status = ST_STQ;
        else if (!any_free)            status = ST_FULL;
        else if (group_stall)          status = ST_GROUP;
        else                           status = ST_OK;
    end
endmodule

// File: rtl/iq_pick.sv
module iq_pick
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] rdy_vec,
    input  logic [DEPTH-1:0] urg_vec,
    input  rank_t            rank_i [DEPTH],
    input  age_t             age_i  [DEPTH],
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic  b_urg;
    rank_t b_rank;
    age_t  b_age;

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        b_urg  = 1'b0;
        b_rank = '0;
        b_age  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rdy_vec[i] && (!found ||
                beats(urg_vec[i], rank_i[i], age_i[i], b_urg, b_rank, b_age))) begin
                found  = 1'b1;
                idx    = IDX_W'(i);
                b_urg  = urg_vec[i];
                b_rank = rank_i[i];
                b_age  = age_i[i];
            end
        end
    end
endmodule

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc,
    input  disp_t  alloc_d,
    input  logic   alloc_exec,
    input  logic   wake,
    input  logic   mclr,
    input  logic   issue_sel,
    output phase_e phase,
    output age_t   age,
    output rank_t  rank,
    output logic   urgent,
    output logic   done
);
    disp_t  ent;
    phase_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_FREE;
            ent <= '0;
        end else if (alloc) begin
            ent <= alloc_d;
            if (alloc_exec)                          ph <= PH_EXEC;
            else if (alloc_d.op_rdy && alloc_d.mem_clr) ph <= PH_READY;
            else                                     ph <= PH_WAIT;
        end else begin
            unique case (ph)
                PH_WAIT: begin
                    ent.op_rdy  <= ent.op_rdy | wake;
                    ent.mem_clr <= ent.mem_clr | mclr;
                    if ((ent.op_rdy | wake) && (ent.mem_clr | mclr)) ph <= PH_READY;
                end
                PH_READY: if (issue_sel) ph <= PH_EXEC;
                PH_EXEC: begin
                    if (ent.lat == '0) ph <= PH_FREE;
                    else               ent.lat <= ent.lat - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign phase  = ph;
    assign age    = ent.age;
    assign rank   = rank_of(ent.age, ent.users);
    assign urgent = ent.urgent;
    assign done   = (ph == PH_EXEC) && (ent.lat == '0);
endmodule

// File: rtl/rank_issue_queue.sv
module rank_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_valid,
    input  logic [AGE_W-1:0] disp_age,
    input  logic [USR_W-1:0] disp_users,
    input  logic [LAT_W-1:0] disp_lat,
    input  logic             disp_opnd_rdy,
    input  logic             disp_mem_clr,
    input  logic             disp_is_load,
    input  logic             disp_is_store,
    input  logic             disp_urgent,
    input  logic             ldq_full,
    input  logic             stq_full,
    input  logic             group_stall,
    output logic [2:0]       disp_status,
    output logic             disp_accept,
    output logic [IDX_W-1:0] disp_slot,
    input  logic             wake_valid,
    input  logic [IDX_W-1:0] wake_idx,
    input  logic             mclr_valid,
    input  logic [IDX_W-1:0] mclr_idx,
    input  logic             res_avail,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_idx,
    output logic [AGE_W-1:0] issue_age,
    output logic [DEPTH-1:0] done_mask
);
    phase_e           phase  [DEPTH];
    age_t             age_v  [DEPTH];
    rank_t            rank_v [DEPTH];
    logic [DEPTH-1:0] free_vec, occ_vec, rdy_vec, urg_vec;
    disp_st_e         status;
    logic             pick_found, bypass, pool_issue;
    logic [IDX_W-1:0] pick_idx;
    disp_t            new_d;

    iq_admit #(.DEPTH(DEPTH)) u_admit (
        .free_vec(free_vec), .is_load(disp_is_load), .is_store(disp_is_store),
        .ldq_full(ldq_full), .stq_full(stq_full), .group_stall(group_stall),
        .status(status), .slot(disp_slot)
    );

    assign disp_status = status;
    assign disp_accept = disp_valid && (status == ST_OK);
    assign bypass      = disp_accept && disp_opnd_rdy && disp_mem_clr && res_avail
                         && ((disp_lat == '0) || disp_urgent);
    assign pool_issue  = res_avail && pick_found && !bypass;

    assign new_d = '{age: disp_age, users: disp_users, lat: disp_lat,
                     urgent: disp_urgent, op_rdy: disp_opnd_rdy, mem_clr: disp_mem_clr};

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic dn;
        iq_slot u_slot (
            .clk(clk), .rst(rst),
            .alloc(disp_accept && (disp_slot == IDX_W'(i))),
            .alloc_d(new_d), .alloc_exec(bypass),
            .wake(wake_valid && (wake_idx == IDX_W'(i))),
            .mclr(mclr_valid && (mclr_idx == IDX_W'(i))),
            .issue_sel(pool_issue && (pick_idx == IDX_W'(i))),
            .phase(phase[i]), .age(age_v[i]), .rank(rank_v[i]),
            .urgent(urg_vec[i]), .done(dn)
        );
        assign free_vec[i]  = (phase[i] == PH_FREE);
        assign occ_vec[i]   = !free_vec[i];
        assign rdy_vec[i]   = (phase[i] == PH_READY);
        assign done_mask[i] = dn;
    end

    iq_pick #(.DEPTH(DEPTH)) u_pick (
        .rdy_vec(rdy_vec), .urg_vec(urg_vec), .rank_i(rank_v), .age_i(age_v),
        .found(pick_found), .idx(pick_idx)
    );

    assign issue_valid = bypass || pool_issue;
    assign issue_idx   = bypass ? disp_slot : pick_idx;
    assign issue_age   = bypass ? disp_age  : age_v[pick_idx];
endmodule

// File: rtl/rank_issue_queue_chk.sv
module rank_issue_queue_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic [2:0]       disp_status,
    input logic             disp_accept,
    input logic [IDX_W-1:0] disp_slot,
    input logic             res_avail,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_idx,
    input logic             bypass,
    input logic [DEPTH-1:0] occ_vec,
    input logic [DEPTH-1:0] rdy_vec,
    input logic [DEPTH-1:0] done_mask
);
    p_status_range_r1: assert property (@(posedge clk) disable iff (rst)
        disp_status <= 3'd4);

    p_accept_ok_r2: assert property (@(posedge clk) disable iff (rst)
        disp_accept |-> (disp_valid && disp_status == 3'd0));

    p_slot_taken_r10: assert property (@(posedge clk) disable iff (rst)
        disp_accept |=> occ_vec[$past(disp_slot)]);

    p_issue_needs_res_r7: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> res_avail);

    p_issue_from_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !bypass) |-> rdy_vec[issue_idx]);

    p_retire_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (|done_mask) |=> ((occ_vec & $past(done_mask)) == '0));
endmodule

bind rank_issue_queue rank_issue_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_status(disp_status),
    .disp_accept(disp_accept), .disp_slot(disp_slot), .res_avail(res_avail),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .bypass(bypass),
    .occ_vec(occ_vec), .rdy_vec(rdy_vec), .done_mask(done_mask)
);

// File: tb/tb_rank_issue_queue.sv
module tb_rank_issue_queue;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int N      = 6;
    localparam logic [7:0] T_AGE [N] = '{8'd10, 8'd12, 8'd14, 8'd15, 8'd20, 8'd11};
    localparam logic [3:0] T_USR [N] = '{4'd0, 4'd5, 4'd7, 4'd1, 4'd12, 4'd1};
    localparam logic [7:0] T_EXP [N] = '{8'd12, 8'd14, 8'd20, 8'd10, 8'd11, 8'd15};

    logic clk = 0, rst = 1;
    logic disp_valid = 0, disp_opnd_rdy = 0, disp_mem_clr = 0, disp_is_load = 0;
    logic disp_is_store = 0, disp_urgent = 0, ldq_full = 0, stq_full = 0, group_stall = 0;
    logic [7:0] disp_age = 0;
    logic [3:0] disp_users = 0, disp_lat = 0;
    logic wake_valid = 0, mclr_valid = 0, res_avail = 0;
    logic [2:0] wake_idx = 0, mclr_idx = 0;
    logic [2:0] disp_status, disp_slot, issue_idx;
    logic disp_accept, issue_valid;
    logic [7:0] issue_age, done_mask;
    int n_chk = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    rank_issue_queue #(.DEPTH(DEPTH)) dut (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic set_disp(input int age, input int usr, input int lat,
                            input logic op, input logic mc, input logic urg);
        disp_valid = 1; disp_age = 8'(age); disp_users = 4'(usr); disp_lat = 4'(lat);
        disp_opnd_rdy = op; disp_mem_clr = mc; disp_urgent = urg;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check(issue_valid == 0, "R7 reset", issue_valid, 0);
        check(done_mask == 0, "R8 reset", done_mask, 0);
        check(disp_status == 0, "R1 reset", disp_status, 0);

        // rank table: fill with resource off, then drain one per cycle
        for (int i = 0; i < N; i++) begin
            set_disp(T_AGE[i], T_USR[i], 15, 1, 1, 0);
            #1;
            check(disp_slot == 3'(i), "R10 slot", disp_slot, i);
            tick();
        end
        disp_valid = 0;
        #1;
        check(issue_valid == 0, "R7 no resource", issue_valid, 0);
        res_avail = 1;
        for (int i = 0; i < N; i++) begin
            #1;
            check(issue_valid && issue_age == T_EXP[i], "R5/R6 order", issue_age, T_EXP[i]);
            tick();
        end
        #1;
        check(issue_valid == 0, "R7 empty pool", issue_valid, 0);
        res_avail = 0;

        // stall encodings
        do_reset();
        ldq_full = 1; stq_full = 1; disp_is_load = 1; set_disp(1, 0, 1, 1, 1, 0);
        #1;
        check(disp_status == 1, "R1 load full", disp_status, 1);
        check(disp_accept == 0, "R2 reject", disp_accept, 0);
        disp_is_load = 0; disp_is_store = 1;
        #1;
        check(disp_status == 2, "R1 store full", disp_status, 2);
        disp_is_store = 0; group_stall = 1;
        #1;
        check(disp_status == 4, "R1 group", disp_status, 4);
        disp_is_load = 1; group_stall = 0; res_avail = 1;
        tick();
        disp_valid = 0;
        #1;
        check(issue_valid == 0, "R2 rejected ignored", issue_valid, 0);
        ldq_full = 0; stq_full = 0; disp_is_load = 0; res_avail = 0;
        for (int i = 0; i < DEPTH; i++) begin
            set_disp(i, 0, 1, 0, 0, 0);
            tick();
        end
        group_stall = 1;
        #1;
        check(disp_status == 3, "R1 full before group", disp_status, 3);
        disp_valid = 0; group_stall = 0;

        // waiting and wakeup
        do_reset();
        set_disp(5, 0, 1, 0, 1, 0);
        tick();
        disp_valid = 0; res_avail = 1;
        #1;
        check(issue_valid == 0, "R3 waits", issue_valid, 0);
        mclr_valid = 1; mclr_idx = 0;
        tick();
        mclr_valid = 0;
        #1;
        check(issue_valid == 0, "R4 memory alone", issue_valid, 0);
        wake_valid = 1; wake_idx = 0;
        tick();
        wake_valid = 0;
        #1;
        check(issue_valid == 1 && issue_idx == 0, "R4 promoted", issue_valid, 1);
        res_avail = 0;

        // latency countdown
        do_reset();
        set_disp(7, 0, 3, 1, 1, 0);
        tick();
        disp_valid = 0; res_avail = 1;
        #1;
        check(issue_valid == 1, "R3 ready at dispatch", issue_valid, 1);
        tick();
        res_avail = 0;
        #1;
        check(done_mask == 0, "R8 e0", done_mask, 0);
        tick(); #1; check(done_mask == 0, "R8 e1", done_mask, 0);
        tick(); #1; check(done_mask == 0, "R8 e2", done_mask, 0);
        tick(); #1; check(done_mask == 8'h01, "R8 e3", done_mask, 1);
        tick(); #1; check(done_mask == 0, "R8 e4", done_mask, 0);

        // zero-latency bypass
        do_reset();
        set_disp(1, 0, 5, 1, 1, 0);
        tick();
        set_disp(100, 0, 0, 1, 1, 0); res_avail = 1;
        #1;
        check(issue_valid && issue_idx == 1, "R9 bypass", issue_idx, 1);
        tick();
        disp_valid = 0;
        #1;
        check(done_mask == 8'h02, "R8 zero latency", done_mask, 2);
        check(issue_valid && issue_idx == 0, "R9 pool next", issue_idx, 0);
        res_avail = 0;

        // urgent in pool
        do_reset();
        set_disp(5, 0, 2, 1, 1, 0);
        tick();
        set_disp(60, 0, 2, 1, 1, 1);
        tick();
        disp_valid = 0;
        #1;
        check(issue_valid == 0, "R7 resource low", issue_valid, 0);
        res_avail = 1;
        #1;
        check(issue_valid && issue_idx == 1, "R9 urgent first", issue_idx, 1);
        res_avail = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule